// File: doc/BRIEF.md
# Variable-Period Request Timer Channel

This block is one timer channel with two modes. In baud mode it is a free-running clock divider. Its output toggles every time the period counter runs out, so the output period is two programmed periods. In task mode it is a request generator. When the counter runs out, the channel raises a request and holds it until the consumer acknowledges. The next period is counted only from the acknowledge onward. The spacing between requests therefore follows the consumer's response time, and the channel has no error or interrupt output.

Software programs the channel through a single-cycle write port that carries the mode, a one-bit clock select and the period. Every write restarts the channel. The counter steps once per tick. With the clock select at 0, every system clock cycle is a tick. With the select at 1, a tick is a rising edge of an external clock, taken through a two-flop synchroniser and an edge detector. That external clock must run at half the system clock frequency or slower.

The controller has four states:
- `ST_IDLE`: after reset, before the first write.
- `ST_BAUD`: free-running divider.
- `ST_TASK`: counting toward the next request.
- `ST_WAIT`: request raised, waiting for the acknowledge.

Its transitions are:
- any state to `ST_BAUD` or `ST_TASK` on a write, chosen by the written mode;
- `ST_TASK` to `ST_WAIT` when the counter expires;
- `ST_WAIT` to `ST_TASK` on the acknowledge.

Top module: `varperiod_timer`

## Requirements
- R1: After reset `req_out` is 0 and stays 0 until the first configuration write.
- R2: A write (`cfg_we`=1) captures `cfg_mode` (0 = baud, 1 = task), `cfg_clk_sel` and `cfg_period`, and restarts the channel: in the cycle after the write `req_out` is 0, even if a request was pending.
- R3: The effective period P equals `cfg_period`, except that a value of 0 counts as 1.
- R4: In baud mode `req_out` first toggles P ticks after the write and then toggles every P ticks without stopping.
- R5: In task mode `req_out` rises P ticks after the write.
- R6: In task mode a raised request stays high, and the counter does not advance, until `ack_in` is sampled high.
- R7: When `ack_in` is sampled high while a request is pending, `req_out` is 0 in the next cycle and the next request rises P ticks after that acknowledge.
- R8: `ack_in` has no effect in baud mode, and it has no effect in task mode while no request is pending.
- R9: With `cfg_clk_sel`=1, a tick is one synchronised rising edge of `ext_clk` (two flops then edge detect). With an external clock of period 4 system cycles, a baud period of P=2 toggles the output every 8 cycles. With `ext_clk` held still, the output does not change.
- R10: With `cfg_clk_sel`=1, ticks never occur in two consecutive system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 1 | 0 = baud mode, 1 = task mode |
| cfg_clk_sel | input | 1 | 0 = count system cycles, 1 = count external clock edges |
| cfg_period | input | CNT_W | Period in ticks (0 is taken as 1) |
| ext_clk | input | 1 | External count clock, asynchronous |
| ack_in | input | 1 | Acknowledge of the pending request |
| req_out | output | 1 | Baud output or task request |

## Verification
The hardest situations to reach are acknowledges that arrive at times that should do nothing: during counting in task mode, in baud mode, and a rewrite while a request is still pending. The stimulus holds `ack_in` high across several cycles of an active count and checks that the request still rises exactly P cycles after the real acknowledge. It also issues a write while the request is high. The external clock path is exercised by a divider in the bench that produces an edge-aligned clock of period 4. The bench measures the steady-state toggle spacing, then stops that clock and checks that the output freezes.

// File: rtl/varperiod_pkg.sv
package varperiod_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BAUD = 2'd1,
        ST_TASK = 2'd2,
        ST_WAIT = 2'd3
    } vp_state_e;

    typedef enum logic {
        MODE_BAUD = 1'b0,
        MODE_TASK = 1'b1
    } vp_mode_e;

endpackage

// File: rtl/vp_tick_gen.sv
module vp_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_ext,
    input  logic ext_clk,
    output logic tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], ext_clk};
    end

    assign ext_rise = sh_q[SH_W-2] & ~sh_q[SH_W-1];

    generate
        if (SYNC_STAGES < 2) begin : g_bad
            initial $error("vp_tick_gen: SYNC_STAGES must be at least 2");
        end
    endgenerate

    always_comb begin
        tick = sel_ext ? ext_rise : 1'b1;
    end

    AST_EXT_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext && ext_rise) |=> !ext_rise); // R10

endmodule

// File: rtl/vp_down_counter.sv
module vp_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = en & tick & (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (en && tick)  cnt_q <= cnt_q - 1'b1;
    end

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(en && tick)) |=> $stable(cnt_q)); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && tick) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/vp_ctrl_fsm.sv
module vp_ctrl_fsm
    import varperiod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_mode,
    input  logic expire,
    input  logic ack_in,
    output logic cnt_en,
    output logic cnt_load,
    output logic req_out
);
    vp_state_e state_q, state_d;
    logic      baud_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = (vp_mode_e'(cfg_mode) == MODE_TASK) ? ST_TASK : ST_BAUD;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_BAUD: state_d = ST_BAUD;
                ST_TASK: state_d = expire ? ST_WAIT : ST_TASK;
                ST_WAIT: state_d = ack_in ? ST_TASK : ST_WAIT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             baud_q <= 1'b0;
        else if (cfg_we)                        baud_q <= 1'b0;
        else if (state_q == ST_BAUD && expire)  baud_q <= ~baud_q;
    end

    always_comb begin
        cnt_en   = !cfg_we && (state_q == ST_BAUD || state_q == ST_TASK);
        cnt_load = cfg_we || expire;
        unique case (state_q)
            ST_IDLE: req_out = 1'b0;
            ST_BAUD: req_out = baud_q;
            ST_TASK: req_out = 1'b0;
            ST_WAIT: req_out = 1'b1;
            default: req_out = 1'b0;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !req_out); // R1

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !req_out); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !ack_in && !cfg_we) |=> req_out); // R6

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ack_in && !cfg_we) |=> (!req_out && state_q == ST_TASK)); // R7

    AST_BAUD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BAUD && !expire && !cfg_we) |=> $stable(req_out)); // R8

endmodule

// File: rtl/varperiod_timer.sv
module varperiod_timer #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_mode,
    input  logic             cfg_clk_sel,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             ext_clk,
    input  logic             ack_in,
    output logic             req_out
);
    logic [CNT_W-1:0] period_q;
    logic             sel_q;
    logic             tick, expire, cnt_en, cnt_load;
    logic [CNT_W-1:0] reload_src, reload_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            sel_q    <= 1'b0;
        end else if (cfg_we) begin
            period_q <= cfg_period;
            sel_q    <= cfg_clk_sel;
        end
    end

    always_comb begin
        reload_src = cfg_we ? cfg_period : period_q;
        reload_val = (reload_src == '0) ? '0 : reload_src - 1'b1;
    end

    vp_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_ext (sel_q),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    vp_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (reload_val),
        .en       (cnt_en),
        .tick     (tick),
        .expire   (expire)
    );

    vp_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .expire   (expire),
        .ack_in   (ack_in),
        .cnt_en   (cnt_en),
        .cnt_load (cnt_load),
        .req_out  (req_out)
    );

    AST_NO_TICK_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !expire); // R9

endmodule

// File: tb/varperiod_timer_tb.sv
module varperiod_timer_tb;
    localparam int CNT_W = 16;
    localparam int NV    = 6;
    localparam int VMODE [NV] = '{0, 0, 0, 1, 1, 1};
    localparam int VPER  [NV] = '{1, 3, 0, 1, 5, 0};
    localparam int VEXP  [NV] = '{1, 3, 1, 1, 5, 1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0, cfg_mode = 1'b0, cfg_clk_sel = 1'b0;
    logic [CNT_W-1:0] cfg_period = '0;
    logic             ext_clk = 1'b0, ack_in = 1'b0;
    logic             req_out;
    logic             ext_run = 1'b0;
    int               ext_div = 0;
    int               errors = 0, checks = 0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (ext_run) begin
            if (ext_div == 1) begin
                ext_clk <= ~ext_clk;
                ext_div <= 0;
            end else begin
                ext_div <= ext_div + 1;
            end
        end
    end

    varperiod_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_clk_sel(cfg_clk_sel), .cfg_period(cfg_period), .ext_clk(ext_clk),
        .ack_in(ack_in), .req_out(req_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit m, input bit sel, input int per);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_clk_sel = sel; cfg_period = CNT_W'(per);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_change(input int limit, output int n);
        logic prev;
        prev = req_out;
        n = -1;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (req_out != prev) begin
                n = k;
                return;
            end
        end
    endtask

    task automatic ack_pulse();
        ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, bad;
        @(negedge clk);
        check("R1 reset level", int'(req_out), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (req_out !== 1'b0) bad++;
        end
        check("R1 quiet before first write", bad, 0);

        for (int v = 0; v < NV; v++) begin
            cfg_write(VMODE[v][0], 1'b0, VPER[v]);
            check("R2 low after write", int'(req_out), 0);
            wait_change(100, n);
            if (VMODE[v] == 0) begin
                check("R4 R3 first toggle", n, VEXP[v]);
                wait_change(100, n);
                check("R4 R3 next toggle", n, VEXP[v]);
            end else begin
                check("R5 R3 first request", n, VEXP[v]);
                check("R5 request level", int'(req_out), 1);
                ack_pulse();
                check("R7 drop after ack", int'(req_out), 0);
                wait_change(100, n);
                check("R7 R3 next request", n, VEXP[v]);
                ack_pulse();
            end
        end

        cfg_write(1'b1, 1'b0, 4);
        wait_change(100, n);
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (req_out !== 1'b1) bad++;
        end
        check("R6 held without ack", bad, 0);
        ack_pulse();
        wait_change(100, n);
        check("R6 R7 count resumes after ack", n, 4);

        ack_pulse();
        n = -1;
        for (int k = 1; k <= 40; k++) begin
            ack_in = (k >= 2 && k <= 5);
            @(negedge clk);
            if (req_out === 1'b1 && n < 0) n = k;
        end
        ack_in = 1'b0;
        check("R8 ack during count ignored", n, 4);

        cfg_write(1'b1, 1'b0, 3);
        wait_change(100, n);
        cfg_write(1'b1, 1'b0, 6);
        check("R2 write drops pending request", int'(req_out), 0);
        wait_change(100, n);
        check("R2 new period after rewrite", n, 6);

        cfg_write(1'b0, 1'b0, 4);
        ack_in = 1'b1;
        wait_change(100, n);
        check("R8 baud ignores ack first", n, 4);
        wait_change(100, n);
        check("R8 baud ignores ack next", n, 4);
        ack_in = 1'b0;

        ext_run = 1'b1;
        repeat (4) @(negedge clk);
        cfg_write(1'b0, 1'b1, 2);
        wait_change(100, n);
        check("R9 external first toggle seen", int'(n > 0), 1);
        wait_change(100, n);
        check("R9 external toggle spacing", n, 8);
        wait_change(100, n);
        check("R9 R10 external toggle spacing again", n, 8);
        ext_run = 1'b0;
        repeat (6) @(negedge clk);
        wait_change(40, n);
        check("R9 stopped external clock freezes output", n, -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule